// File: doc/BRIEF.md
# Four-bit mode-selected mini ALU

This block is a purely combinational arithmetic unit for two 4-bit operands. A 2-bit mode input picks one of four fixed operations: a constant zero, the bitwise inverse of operand A, the two's-complement negation of A, or the sum of A and B. The unit returns a 4-bit result and a carry flag.

All four operations pass through a single ripple-carry adder built from chained 1-bit full adder cells. A steering stage chooses the adder's two operands and its carry-in for each mode. A gate then passes the adder's carry to the carry flag only in the two arithmetic modes. The block has no clock and no state. A parent design that needs timing places registers around it.

Top module: `mini_alu`

## Requirements
- R1: With mode 2'b00, the result is 4'b0000 and the carry flag is 0 for every A and B.
- R2: With mode 2'b01, the result is the bitwise inverse of A (A=0101 gives 1010) and the carry flag is 0.
- R3: With mode 2'b10, the result is the two's-complement negation of A modulo 16, meaning the inverse of A plus one (A=0101 gives 1011).
- R4: With mode 2'b10, the carry flag is 1 exactly when A is 4'b0000.
- R5: With mode 2'b11, the result is the low four bits of A+B (0101+0011 gives 1000).
- R6: With mode 2'b11, the carry flag is bit 4 of A+B (1111+0001 gives result 0000 and carry 1).
- R7: In modes 2'b00, 2'b01 and 2'b10, the value of B has no effect on either output.
- R8: Each of the four chained full adder stages produces the sum bit and carry bit of its three input bits, and each stage's carry-out feeds the next stage's carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First operand |
| op_b | input | 4 | Second operand, used only in the add mode |
| mode | input | 2 | Operation select: 00 zero, 01 invert A, 10 negate A, 11 add |
| res | output | 4 | Result |
| co | output | 1 | Carry flag |

## Verification
The bench tries all 1024 combinations of mode, A and B, so every carry path through the chain is driven, including the full ripple from bit 0 to bit 4. In the add mode these combinations separate a correct sum from a carry that is dropped or misplaced. In the negate mode, the case A=0000 is the only one that sets the carry, so it tells a carry-in of one apart from a missing or inverted increment. In the three modes that ignore B, each output is compared with the output for B=0000, which exposes any leak of B into the adder. The worked examples from the requirements are also checked on their own.

// File: rtl/mini_alu_pkg.sv
// Package mini_alu_pkg
// Holds the shared width parameter and the encoding of the operation modes.
// Assumes the mode bus is two bits wide and every code value is used.
package mini_alu_pkg;

    localparam int unsigned ALU_W = 4;

    typedef enum logic [1:0] {
        OP_ZERO = 2'b00,
        OP_INV  = 2'b01,
        OP_NEG  = 2'b10,
        OP_ADD  = 2'b11
    } alu_op_e;

endpackage

// File: rtl/fa_cell.sv
// Module fa_cell
// One-bit full adder. It adds x, y and the incoming carry to give a sum bit and a
// carry bit.
// Assumes nothing about its neighbours. The carry chain is built by its parent.
module fa_cell (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic c
);

    // Form the sum bit and the majority carry.
    always_comb begin
        s = x ^ y ^ ci;
        c = (x & y) | (ci & (x ^ y));
    end

    // The two output bits must equal the arithmetic total of the three input bits.
    always_comb begin
        assert_cell_total_R8: assert ({c, s} == ({1'b0, x} + {1'b0, y} + {1'b0, ci}))
            else $error("fa_cell total mismatch");
    end

endmodule

// File: rtl/ripple_add.sv
// Module ripple_add
// WIDTH-bit ripple-carry adder. It builds a chain of fa_cell stages, and each
// stage's carry-out drives the next stage's carry-in.
// Assumes WIDTH >= 1. The delay grows linearly with WIDTH.
module ripple_add #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             ci,
    output logic [WIDTH-1:0] s,
    output logic             co
);

    localparam int unsigned CW = WIDTH + 1;

    logic [WIDTH:0] chain;

    // Feed the external carry-in into the bottom stage.
    assign chain[0] = ci;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        fa_cell u_fa (
            .x  (x[i]),
            .y  (y[i]),
            .ci (chain[i]),
            .s  (s[i]),
            .c  (chain[i+1])
        );
    end

    // Pass the top stage's carry out of the adder.
    assign co = chain[WIDTH];

    // The whole chain must equal the arithmetic sum of its inputs.
    always_comb begin
        assert_chain_total_R8: assert ({co, s} ==
                                       (CW'(x) + CW'(y) + CW'(ci)))
            else $error("ripple_add chain mismatch");
    end

endmodule

// File: rtl/op_steer.sv
// Module op_steer
// Chooses the adder's two operands and its carry-in for each operation, and says
// whether the adder's carry may reach the carry flag.
// Assumes the adder computes x + y + ci.
module op_steer
    import mini_alu_pkg::*;
#(
    parameter int unsigned WIDTH = ALU_W
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] add_x,
    output logic [WIDTH-1:0] add_y,
    output logic             add_ci,
    output logic             keep_carry
);

    // Decode the operation into the adder's inputs and the carry gate.
    always_comb begin
        add_x      = '0;
        add_y      = '0;
        add_ci     = 1'b0;
        keep_carry = 1'b0;
        unique case (op)
            OP_ZERO: ;
            OP_INV: begin
                add_x = ~a;
            end
            OP_NEG: begin
                add_x      = ~a;
                add_ci     = 1'b1;
                keep_carry = 1'b1;
            end
            OP_ADD: begin
                add_x      = a;
                add_y      = b;
                keep_carry = 1'b1;
            end
            default: ;
        endcase
    end

    // Operand B may reach the adder only in the add mode.
    always_comb begin
        assert_b_isolated_R7: assert ((op == OP_ADD) || (add_y == '0))
            else $error("op_steer leaked B into the adder");
    end

endmodule

// File: rtl/mini_alu.sv
// Module mini_alu
// Combinational four-operation ALU: zero, invert A, negate A, or add A and B.
// Every operation goes through one shared ripple adder. The carry flag is gated
// so that it can be set only in the negate and add modes.
// Assumes its parent registers the inputs and outputs if timing needs it.
module mini_alu
    import mini_alu_pkg::*;
(
    input  logic [3:0] op_a,
    input  logic [3:0] op_b,
    input  logic [1:0] mode,
    output logic [3:0] res,
    output logic       co
);

    localparam int unsigned W  = ALU_W;
    localparam int unsigned CW = W + 1;

    alu_op_e        op;
    logic [W-1:0]   add_x;
    logic [W-1:0]   add_y;
    logic           add_ci;
    logic           keep_carry;
    logic [W-1:0]   add_s;
    logic           add_co;

    // Convert the raw mode bits into the operation type.
    assign op = alu_op_e'(mode);

    op_steer #(.WIDTH(W)) u_steer (
        .op         (op),
        .a          (op_a),
        .b          (op_b),
        .add_x      (add_x),
        .add_y      (add_y),
        .add_ci     (add_ci),
        .keep_carry (keep_carry)
    );

    ripple_add #(.WIDTH(W)) u_add (
        .x  (add_x),
        .y  (add_y),
        .ci (add_ci),
        .s  (add_s),
        .co (add_co)
    );

    // Drive the result from the adder and gate its carry into the flag.
    always_comb begin
        res = add_s;
        co  = add_co & keep_carry;
    end

    // Check each mode's outputs against an arithmetic relation on the operands.
    always_comb begin
        if (op == OP_ZERO) begin
            assert_zero_out_R1: assert (res == '0 && !co)
                else $error("zero mode output nonzero");
        end
        if (op == OP_INV) begin
            assert_inv_out_R2: assert (((res ^ op_a) == {W{1'b1}}) && !co)
                else $error("invert mode output wrong");
        end
        if (op == OP_NEG) begin
            assert_neg_sum_R3: assert (W'(res + op_a) == '0)
                else $error("negate mode result wrong");
            assert_neg_carry_R4: assert (co == (op_a == '0))
                else $error("negate mode carry wrong");
        end
        if (op == OP_ADD) begin
            assert_add_out_R5: assert ({co, res} == (CW'(op_a) + CW'(op_b)))
                else $error("add mode output wrong");
        end
    end

endmodule

// File: tb/test_mini_alu.sv
// Testbench test_mini_alu
// Sweeps every mode and operand pair and compares the outputs with values
// computed arithmetically here.
module test_mini_alu;

    logic       clk;
    logic       rst_n;
    logic [3:0] op_a;
    logic [3:0] op_b;
    logic [1:0] mode;
    logic [3:0] res;
    logic       co;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    mini_alu i_mini_alu (
        .op_a (op_a),
        .op_b (op_b),
        .mode (mode),
        .res  (res),
        .co   (co)
    );

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Record one comparison and report it if it fails.
    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d (mode=%0d a=%0d b=%0d)",
                     tag, got, exp, mode, op_a, op_b);
        end
    endtask

    // Drive one input vector after a falling edge and let it settle.
    task automatic apply(input int m, input int a, input int b);
        @(negedge clk);
        mode = 2'(m);
        op_a = 4'(a);
        op_b = 4'(b);
        #5;
    endtask

    // Stop a hung run and count it as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Main stimulus.
    initial begin
        rst_n = 1'b0;
        mode  = 2'b00;
        op_a  = 4'hF;
        op_b  = 4'hF;
        repeat (3) @(posedge clk);
        #5;
        // R1: the output is zero during reset with mode 00.
        check("R1 reset result", int'(res), 0);
        check("R1 reset carry", int'(co), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Worked examples.
        apply(1, 5, 0);  check("R2 example", int'(res), 10);
        apply(2, 5, 0);  check("R3 example", int'(res), 11);
        apply(2, 0, 9);  check("R4 zero operand carry", int'(co), 1);
        apply(3, 5, 3);  check("R5 example", int'(res), 8);
                         check("R6 example no carry", int'(co), 0);
        apply(3, 15, 1); check("R6 example result", int'(res), 0);
                         check("R6 example carry", int'(co), 1);

        // Full sweep of all modes and operands.
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 16; a++) begin
                int ref_r;
                int ref_c;
                for (int b = 0; b < 16; b++) begin
                    int er;
                    int ec;
                    apply(m, a, b);
                    case (m)
                        0: begin er = 0;                 ec = 0;                    end
                        1: begin er = 15 - a;            ec = 0;                    end
                        2: begin er = (16 - a) % 16;     ec = (a == 0) ? 1 : 0;     end
                        default: begin er = (a + b) % 16; ec = (a + b) / 16;        end
                    endcase
                    case (m)
                        0: begin check("R1 result", int'(res), er); check("R1 carry", int'(co), ec); end
                        1: begin check("R2 result", int'(res), er); check("R2 carry", int'(co), ec); end
                        2: begin check("R3 result", int'(res), er); check("R4 carry", int'(co), ec); end
                        default: begin check("R5 result", int'(res), er); check("R6 carry", int'(co), ec); end
                    endcase
                    if (m == 3 && a == 15 && b == 1)
                        check("R8 full ripple", int'({co, res}), 16);
                    if (m != 3) begin
                        if (b == 0) begin
                            ref_r = int'(res);
                            ref_c = int'(co);
                        end else begin
                            // R7: B has no effect outside the add mode.
                            check("R7 result", int'(res), ref_r);
                            check("R7 carry", int'(co), ref_c);
                        end
                    end
                end
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule